// File: doc/BRIEF.md
# Paired Command Word Queue with Error Classification

This block holds command words for a downstream command sequencer in two independent first-in first-out queues: one for reseed commands and one for generate commands. Software pushes 32-bit words into either queue, and the sequencer pops them in the order they were written. Each queue holds at most 13 words. The head word is always presented on the read data output, so a pop simply advances past it.

Misuse of either queue is classified and recorded. The recorded cases are a push into a full queue, a pop from an empty queue, and a queue whose empty and full flags are both set. Each event sets a source bit that names the queue and a type bit that is shared by both queues. The recorded bits stay set until reset, and any of them raises a fatal error output.

A 4-bit multi-bit clear field empties both queues. A test strobe with a 5-bit bit number forces a single error pulse so that the error paths can be exercised.

Top module: `cmdq_pair`

## Requirements
- R1: Each queue accepts 13 words and then reports full. Its depth output counts the stored words, from 0 to 13.
- R2: Words leave a queue in the order they were written. While a queue is not empty, its read data output shows the oldest stored word.
- R3: A push into a full queue stores nothing and leaves the depth unchanged. On the next cycle the error code has bit 28 set, together with the source bit: bit 0 for the reseed queue, bit 1 for the generate queue.
- R4: A pop from an empty queue leaves the queue unchanged. On the next cycle the error code has bit 29 set, together with the queue's source bit.
- R5: Error code bits never clear except by reset. The fatal output is high exactly when at least one error code bit is set.
- R6: While the clear field equals 4'h6, both queues are empty on the next cycle. Pushes and pops in that cycle are ignored and record no error.
- R7: Pushes are accepted only while the clear field holds its reset value 4'h9. For any other value, pushes are dropped silently and the depth does not grow.
- R8: A test strobe with bit number 0, 1, 28, 29 or 30 sets only that error code bit on the next cycle. Any other bit number leaves the error code unchanged.
- R9: A queue never shows empty and full together. Bit 30 records that condition, together with the source bit, if it ever arises.
- R10: A push and a pop in the same cycle on a partly filled queue both take effect, and the depth stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clr_i | input | 4 | Multi-bit clear field: 4'h6 clears, 4'h9 is the idle value |
| rs_wr_i | input | 1 | Push strobe, reseed queue |
| rs_wdata_i | input | 32 | Push word, reseed queue |
| rs_rd_i | input | 1 | Pop strobe, reseed queue |
| rs_rdata_o | output | 32 | Head word, reseed queue |
| rs_depth_o | output | 4 | Stored word count, reseed queue |
| rs_empty_o | output | 1 | Reseed queue empty |
| rs_full_o | output | 1 | Reseed queue full |
| gn_wr_i | input | 1 | Push strobe, generate queue |
| gn_wdata_i | input | 32 | Push word, generate queue |
| gn_rd_i | input | 1 | Pop strobe, generate queue |
| gn_rdata_o | output | 32 | Head word, generate queue |
| gn_depth_o | output | 4 | Stored word count, generate queue |
| gn_empty_o | output | 1 | Generate queue empty |
| gn_full_o | output | 1 | Generate queue full |
| test_we_i | input | 1 | Error injection strobe |
| test_sel_i | input | 5 | Error code bit number to inject |
| err_o | output | 32 | Sticky error code |
| fatal_o | output | 1 | Any error code bit set |

## Verification
Depth, the empty and full flags, and the error code all change at the rising edge that samples the strobe, so each of them is due one cycle after the stimulus. The head word changes at the same edge. The bench drives its inputs just after a falling edge and reads these results at the next falling edge, half a period after the register update. The monitor takes each popped word at the rising edge that accepts the pop, because the word is already shown there, and compares it with the front of the scoreboard queue.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned ERR_W    = 32;
  localparam int unsigned SEL_W    = 5;
  localparam logic [3:0]  MB_TRUE  = 4'h6;
  localparam logic [3:0]  MB_FALSE = 4'h9;
  localparam int unsigned BIT_WR   = 28;
  localparam int unsigned BIT_RD   = 29;
  localparam int unsigned BIT_ST   = 30;

  typedef struct packed {
    logic wr;
    logic rd;
    logic st;
  } qerr_t;
endpackage

// File: rtl/cmdq_fifo.sv
module cmdq_fifo #(
  parameter int unsigned DEPTH = 13,
  parameter int unsigned WIDTH = 32,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               wr_i,
  input  logic [WIDTH-1:0]   wdata_i,
  input  logic               rd_i,
  output logic [WIDTH-1:0]   rdata_o,
  output logic [CNT_W-1:0]   depth_o,
  output logic               empty_o,
  output logic               full_o,
  output cmdq_pkg::qerr_t    err_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             empty_q, empty_d, full_q, full_d;
  logic             wr_ok, rd_ok;

  assign wr_ok = wr_i & ~full_q;
  assign rd_ok = rd_i & ~empty_q;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (clr_i) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (wr_ok) wptr_d = (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
      if (rd_ok) rptr_d = (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
      cnt_d = cnt_q + CNT_W'(wr_ok) - CNT_W'(rd_ok);
    end
    empty_d = (cnt_d == '0);
    full_d  = (cnt_d == CNT_W'(DEPTH));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      cnt_q   <= '0;
      empty_q <= 1'b1;
      full_q  <= 1'b0;
    end else begin
      wptr_q  <= wptr_d;
      rptr_q  <= rptr_d;
      cnt_q   <= cnt_d;
      empty_q <= empty_d;
      full_q  <= full_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_ok && !clr_i) mem_q[wptr_q] <= wdata_i;
  end

  assign rdata_o = mem_q[rptr_q];
  assign depth_o = cnt_q;
  assign empty_o = empty_q;
  assign full_o  = full_q;

  assign err_o.wr = wr_i & full_q & ~clr_i;
  assign err_o.rd = rd_i & empty_q & ~clr_i;
  assign err_o.st = empty_q & full_q;
endmodule

// File: rtl/cmdq_errlog.sv
module cmdq_errlog #(
  parameter int unsigned NSRC = 2
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  cmdq_pkg::qerr_t [NSRC-1:0]          err_i,
  input  logic                                test_we_i,
  input  logic [cmdq_pkg::SEL_W-1:0]          test_sel_i,
  output logic [cmdq_pkg::ERR_W-1:0]          code_o
);
  import cmdq_pkg::*;

  localparam logic [ERR_W-1:0] SRC_MASK = ERR_W'((1 << NSRC) - 1);
  localparam logic [ERR_W-1:0] VALID_MASK = SRC_MASK
      | (ERR_W'(1) << BIT_WR) | (ERR_W'(1) << BIT_RD) | (ERR_W'(1) << BIT_ST);

  logic [ERR_W-1:0] code_q, code_d, set_v;

  always_comb begin
    set_v = '0;
    for (int i = 0; i < NSRC; i++) begin
      set_v[i]      = |err_i[i];
      set_v[BIT_WR] = set_v[BIT_WR] | err_i[i].wr;
      set_v[BIT_RD] = set_v[BIT_RD] | err_i[i].rd;
      set_v[BIT_ST] = set_v[BIT_ST] | err_i[i].st;
    end
    if (test_we_i) set_v = set_v | ((ERR_W'(1) << test_sel_i) & VALID_MASK);
    code_d = code_q | set_v;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_q <= '0;
    else         code_q <= code_d;
  end

  assign code_o = code_q;
endmodule

// File: rtl/cmdq_pair.sv
module cmdq_pair #(
  parameter int unsigned DEPTH = 13,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        clr_i,
  input  logic              rs_wr_i,
  input  logic [31:0]       rs_wdata_i,
  input  logic              rs_rd_i,
  output logic [31:0]       rs_rdata_o,
  output logic [CNT_W-1:0]  rs_depth_o,
  output logic              rs_empty_o,
  output logic              rs_full_o,
  input  logic              gn_wr_i,
  input  logic [31:0]       gn_wdata_i,
  input  logic              gn_rd_i,
  output logic [31:0]       gn_rdata_o,
  output logic [CNT_W-1:0]  gn_depth_o,
  output logic              gn_empty_o,
  output logic              gn_full_o,
  input  logic              test_we_i,
  input  logic [4:0]        test_sel_i,
  output logic [31:0]       err_o,
  output logic              fatal_o
);
  import cmdq_pkg::*;
  localparam int unsigned NQ = 2;

  logic                     clr_hit, wr_open;
  logic [NQ-1:0]            q_wr, q_rd, q_empty, q_full;
  logic [NQ-1:0][WORD_W-1:0] q_wdata, q_rdata;
  logic [NQ-1:0][CNT_W-1:0] q_depth;
  qerr_t [NQ-1:0]           q_err;

  assign clr_hit = (clr_i == MB_TRUE);
  assign wr_open = (clr_i == MB_FALSE);

  assign q_wr    = {gn_wr_i, rs_wr_i} & {NQ{wr_open}};
  assign q_rd    = {gn_rd_i, rs_rd_i} & {NQ{~clr_hit}};
  assign q_wdata = {gn_wdata_i, rs_wdata_i};

  for (genvar g = 0; g < NQ; g++) begin : g_q
    cmdq_fifo #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (clr_hit),
      .wr_i    (q_wr[g]),
      .wdata_i (q_wdata[g]),
      .rd_i    (q_rd[g]),
      .rdata_o (q_rdata[g]),
      .depth_o (q_depth[g]),
      .empty_o (q_empty[g]),
      .full_o  (q_full[g]),
      .err_o   (q_err[g])
    );
  end

  cmdq_errlog #(.NSRC(NQ)) u_errlog (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .err_i      (q_err),
    .test_we_i  (test_we_i),
    .test_sel_i (test_sel_i),
    .code_o     (err_o)
  );

  assign fatal_o    = |err_o;
  assign rs_rdata_o = q_rdata[0];
  assign rs_depth_o = q_depth[0];
  assign rs_empty_o = q_empty[0];
  assign rs_full_o  = q_full[0];
  assign gn_rdata_o = q_rdata[1];
  assign gn_depth_o = q_depth[1];
  assign gn_empty_o = q_empty[1];
  assign gn_full_o  = q_full[1];
endmodule

// File: rtl/cmdq_pair_chk.sv
module cmdq_pair_chk #(
  parameter int unsigned DEPTH = 13,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [3:0]       clr_i,
  input logic             rs_wr_i,
  input logic             rs_rd_i,
  input logic [CNT_W-1:0] rs_depth_o,
  input logic             rs_empty_o,
  input logic             rs_full_o,
  input logic             gn_rd_i,
  input logic [CNT_W-1:0] gn_depth_o,
  input logic             gn_empty_o,
  input logic             gn_full_o,
  input logic [31:0]      err_o
);
  import cmdq_pkg::*;

  assert_depth_cap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rs_depth_o <= CNT_W'(DEPTH)) && (gn_depth_o <= CNT_W'(DEPTH)));

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rs_wr_i && rs_full_o && clr_i == MB_FALSE) |=> (err_o[0] && err_o[BIT_WR]));

  assert_underflow_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gn_rd_i && gn_empty_o && clr_i != MB_TRUE) |=> (err_o[1] && err_o[BIT_RD]));

  assert_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((err_o & $past(err_o)) == $past(err_o)));

  assert_clear_empties_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i == MB_TRUE) |=> (rs_empty_o && gn_empty_o && rs_depth_o == '0));

  assert_push_blocked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i != MB_FALSE && clr_i != MB_TRUE && !rs_rd_i) |=> $stable(rs_depth_o));

  assert_flag_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rs_empty_o && rs_full_o) && !(gn_empty_o && gn_full_o));
endmodule

bind cmdq_pair cmdq_pair_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clr_i      (clr_i),
  .rs_wr_i    (rs_wr_i),
  .rs_rd_i    (rs_rd_i),
  .rs_depth_o (rs_depth_o),
  .rs_empty_o (rs_empty_o),
  .rs_full_o  (rs_full_o),
  .gn_rd_i    (gn_rd_i),
  .gn_depth_o (gn_depth_o),
  .gn_empty_o (gn_empty_o),
  .gn_full_o  (gn_full_o),
  .err_o      (err_o)
);

// File: tb/cmdq_pair_tb_top.sv
module cmdq_pair_tb_top;
  localparam int DEPTH = 13;
  localparam logic [3:0] T_CLR = 4'h6;
  localparam logic [3:0] T_IDLE = 4'h9;

  logic        clk, rst_n;
  logic [3:0]  clr;
  logic        rs_wr, rs_rd, gn_wr, gn_rd, test_we;
  logic [31:0] rs_wdata, gn_wdata, rs_rdata, gn_rdata, err;
  logic [3:0]  rs_depth, gn_depth;
  logic        rs_empty, rs_full, gn_empty, gn_full, fatal;
  logic [4:0]  test_sel;

  int n_chk = 0;
  int n_bad = 0;
  int both_seen = 0;
  logic [31:0] q_rs[$];
  logic [31:0] q_gn[$];
  logic [31:0] exp_err;

  cmdq_pair dut_i (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr),
    .rs_wr_i(rs_wr), .rs_wdata_i(rs_wdata), .rs_rd_i(rs_rd), .rs_rdata_o(rs_rdata),
    .rs_depth_o(rs_depth), .rs_empty_o(rs_empty), .rs_full_o(rs_full),
    .gn_wr_i(gn_wr), .gn_wdata_i(gn_wdata), .gn_rd_i(gn_rd), .gn_rdata_o(gn_rdata),
    .gn_depth_o(gn_depth), .gn_empty_o(gn_empty), .gn_full_o(gn_full),
    .test_we_i(test_we), .test_sel_i(test_sel), .err_o(err), .fatal_o(fatal)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // Monitor: pops scoreboard on every accepted pop (R2)
  always @(posedge clk) begin
    if (rst_n) begin
      if ((rs_empty && rs_full) || (gn_empty && gn_full)) both_seen++;
      if (rs_rd && !rs_empty && clr != T_CLR && q_rs.size() > 0)
        chk("R2 reseed order", rs_rdata, q_rs.pop_front());
      if (gn_rd && !gn_empty && clr != T_CLR && q_gn.size() > 0)
        chk("R2 generate order", gn_rdata, q_gn.pop_front());
    end
  end

  // Driver: one cycle of stimulus, scoreboard and error model updated
  task automatic cyc(input logic rw, input logic [31:0] rd_w, input logic rr,
                     input logic gw, input logic [31:0] gd_w, input logic gr);
    int nr = q_rs.size();
    int ng = q_gn.size();
    rs_wr = rw; rs_wdata = rd_w; rs_rd = rr;
    gn_wr = gw; gn_wdata = gd_w; gn_rd = gr;
    if (clr == T_CLR) begin
      q_rs.delete(); q_gn.delete();
    end else begin
      if (rw && clr == T_IDLE) begin
        if (nr < DEPTH) q_rs.push_back(rd_w);
        else exp_err = exp_err | 32'h1000_0001;
      end
      if (gw && clr == T_IDLE) begin
        if (ng < DEPTH) q_gn.push_back(gd_w);
        else exp_err = exp_err | 32'h1000_0002;
      end
      if (rr && nr == 0) exp_err = exp_err | 32'h2000_0001;
      if (gr && ng == 0) exp_err = exp_err | 32'h2000_0002;
    end
    @(negedge clk);
    rs_wr = 0; rs_rd = 0; gn_wr = 0; gn_rd = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    q_rs.delete(); q_gn.delete();
    exp_err = '0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    clr = T_IDLE; rs_wr = 0; rs_rd = 0; gn_wr = 0; gn_rd = 0;
    rs_wdata = '0; gn_wdata = '0; test_we = 0; test_sel = '0; exp_err = '0;
    rst_n = 0;
    @(negedge clk);
    do_reset();
    // reset state
    chk("R5 reset err", err, 0);
    chk("R5 reset fatal", {31'b0, fatal}, 0);
    chk("R1 reset depth", {28'b0, rs_depth}, 0);
    chk("R1 reset empty", {31'b0, rs_empty}, 1);

    // R1: fill reseed queue
    for (int i = 0; i < DEPTH; i++) cyc(1, 32'hA500_0000 + i, 0, 0, 0, 0);
    chk("R1 depth at capacity", {28'b0, rs_depth}, DEPTH);
    chk("R1 full flag", {31'b0, rs_full}, 1);
    chk("R1 no error on fill", err, 0);
    chk("R2 head word", rs_rdata, 32'hA500_0000);

    // R3: push into full reseed queue
    cyc(1, 32'hDEAD_BEEF, 0, 0, 0, 0);
    chk("R3 depth unchanged", {28'b0, rs_depth}, DEPTH);
    chk("R3 error code", err, exp_err);
    chk("R3 expected bits", exp_err, 32'h1000_0001);
    chk("R5 fatal raised", {31'b0, fatal}, 1);

    // R2: drain reseed queue through monitor
    for (int i = 0; i < DEPTH; i++) cyc(0, 0, 1, 0, 0, 0);
    chk("R2 drained empty", {31'b0, rs_empty}, 1);

    // R4: pop from empty generate queue
    cyc(0, 0, 0, 0, 0, 1);
    chk("R4 error code", err, exp_err);
    chk("R4 expected bits", exp_err, 32'h3000_0003);
    chk("R4 depth unchanged", {28'b0, gn_depth}, 0);

    // R5: sticky over idle cycles
    repeat (5) @(negedge clk);
    chk("R5 sticky", err, 32'h3000_0003);

    do_reset();
    chk("R5 cleared by reset", err, 0);

    // R10: simultaneous push and pop
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 32'h6E00_0000 + i, 0);
    cyc(0, 0, 0, 1, 32'h6E00_00AA, 1);
    chk("R10 depth held", {28'b0, gn_depth}, 3);
    chk("R2 new head", gn_rdata, 32'h6E00_0001);
    chk("R10 no error", err, 0);

    // R6: clear empties both; strobes ignored
    cyc(1, 32'h1111_1111, 0, 0, 0, 0);
    clr = T_CLR;
    cyc(1, 32'h2222_2222, 1, 1, 32'h3333_3333, 1);
    chk("R6 reseed empty", {28'b0, rs_depth}, 0);
    chk("R6 generate empty", {28'b0, gn_depth}, 0);
    cyc(0, 0, 1, 0, 0, 1);
    chk("R6 no error during clear", err, 0);

    // R7: non-idle field blocks pushes
    clr = 4'h3;
    cyc(1, 32'h4444_4444, 0, 1, 32'h5555_5555, 0);
    chk("R7 reseed blocked", {28'b0, rs_depth}, 0);
    chk("R7 generate blocked", {28'b0, gn_depth}, 0);
    chk("R7 no error", err, 0);
    clr = T_IDLE;
    cyc(1, 32'h7777_7777, 0, 0, 0, 0);
    chk("R7 accepted at idle", {28'b0, rs_depth}, 1);
    chk("R2 head after clear", rs_rdata, 32'h7777_7777);

    // R8: error injection
    test_we = 1; test_sel = 5'd29;
    @(negedge clk);
    test_we = 0;
    chk("R8 inject bit 29", err, 32'h2000_0000);
    test_we = 1; test_sel = 5'd5;
    @(negedge clk);
    test_we = 0;
    chk("R8 invalid bit ignored", err, 32'h2000_0000);
    test_we = 1; test_sel = 5'd1;
    @(negedge clk);
    test_we = 0;
    chk("R8 inject bit 1", err, 32'h2000_0002);

    // R9: flags never both set
    chk("R9 empty and full exclusive", both_seen, 0);
    summary();
  end
endmodule